// File: doc/BRIEF.md
# Framebuffer pixel unpacker

This block sits between a framebuffer word fetcher and the colour pipeline of a display controller. It takes one 32-bit word at a time over a valid/ready handshake. It slices the word into pixels and hands them out one per transfer on a second valid/ready handshake.

Depths of 1, 2, 4 and 8 bits produce palette indices for an external lookup. The 16-bit layouts and the 24-bit depth produce direct colour. Direct colour is widened to 8 bits per channel, and the red and blue channels can be swapped.

Three controls set the order of pixels inside a word:
- little-endian order, the default;
- reversed pixel order;
- byte-reversed order, which takes priority over reversed pixel order.

The block comes in two variants. In the original variant, the 16-bit layout is picked by a two-bit external mux input. In the later variant, the depth code alone picks among the 16-bit layouts and a 12-bit layout. The depth, order, swap and mux settings are sampled when a word is accepted.

Top module: `pix_unpack`

## Requirements
- R1: While reset is asserted and after it is released, with no word accepted yet, `pix_valid` is 0 and `word_ready` is 1.
- R2: Depth codes 0..7 map to these container widths: 0=1 bit, 1=2 bits, 2=4 bits, 3=8 bits, 4=16 bits, 5=32 bits (one 24-bit pixel), 6=16 bits, 7=16 bits. A word yields 32/width pixels. While pixels of the current word remain, `word_ready` is 0, except in the cycle the last one is taken. A pixel that is offered but not taken is held unchanged.
- R3: In the cycle the last pixel of a word is taken, `word_ready` is 1, so a waiting word is loaded without an idle cycle between the two words.
- R4: With both order controls at 0, pixel k is taken from word bits [k*w +: w], where w is the container width.
- R5: With `be_pix`=1 and `be_byte`=0, pixel k is taken from bits [(N-1-k)*w +: w], where N is the number of pixels per word.
- R6: With `be_byte`=1, the order is set whatever `be_pix` is. The four bytes of the word are reversed first, and pixel k is then taken from bits [(N-1-k)*w +: w] of the result.
- R7: For depth codes 0..3, `pix_is_index`=1, `pix_index` is the pixel field zero-extended, and `pix_rgb`=0. For direct-colour depths, `pix_is_index`=0 and `pix_index`=0.
- R8: For depth code 5, the low 24 bits of the (possibly byte-reversed) word form the pixel: red from bits [7:0], green from [15:8], blue from [23:16]. Bits [31:24] are ignored.
- R9: In the original variant, depth codes 4, 6 and 7 all mean 16-bit, and the layout follows `mux_sel`:
  - `mux_sel` 1 gives 5551: red [4:0], green [9:5], blue [14:10], bit 15 ignored.
  - `mux_sel` 0 or 2 gives 565: red [4:0], green [10:5], blue [15:11].
  - `mux_sel` 3 gives 565 with the red/blue swap forced on.
- R10: In the later variant, `mux_sel` has no effect. Code 4 gives 5551, code 6 gives 565, and code 7 gives 444 with red [3:0], green [7:4] and blue [11:8].
- R11: Each channel narrower than 8 bits is widened by a left shift with zero fill.
- R12: With `bgr`=1, the red and blue channels swap places. `pix_rgb` is {red[23:16], green[15:8], blue[7:0]} before any swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | Framebuffer word offered |
| word_ready | output | 1 | Block can take a word this cycle |
| word_data | input | 32 | Framebuffer word |
| depth | input | 3 | Depth code |
| bgr | input | 1 | Swap red and blue |
| be_byte | input | 1 | Byte-reversed order (priority) |
| be_pix | input | 1 | Reversed pixel order |
| mux_sel | input | 2 | External 16-bit layout selector |
| pix_valid | output | 1 | Pixel offered |
| pix_ready | input | 1 | Consumer takes the pixel |
| pix_is_index | output | 1 | Pixel is a palette index |
| pix_index | output | 8 | Palette index |
| pix_rgb | output | 24 | Direct colour {R,G,B} |

## Verification
Two things can happen in the same cycle: the consumer takes the final pixel of a word, and the fetcher hands over the next word. The bench offers words on most cycles and lets a pseudo-random ready pattern decide when pixels are taken, so this overlap occurs in many depth and order settings. The bench tracks in its own model which word and pixel should be on the output. It judges each cycle by the expected `word_ready` and `pix_valid`, and by the absence of a gap between the two words.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;

  typedef enum logic [2:0] {
    FMT_INDEX = 3'd0,
    FMT_5551  = 3'd1,
    FMT_565   = 3'd2,
    FMT_444   = 3'd3,
    FMT_888   = 3'd4
  } pix_fmt_e;

  // Settings captured with each word
  typedef struct packed {
    pix_fmt_e   fmt;
    logic [2:0] wlog;      // log2 of container width
    logic       swap;      // red/blue exchange
    logic       bswap;     // reverse bytes before slicing
    logic       msb_first; // pixel 0 at the top of the word
  } unpack_cfg_t;

endpackage

// File: rtl/pix_cfg_decode.sv
module pix_cfg_decode
  import pix_unpack_pkg::*;
#(
  parameter bit LATER_VARIANT = 1'b0
) (
  input  logic [2:0]  depth,
  input  logic        bgr,
  input  logic        be_byte,
  input  logic        be_pix,
  input  logic [1:0]  mux_sel,
  output unpack_cfg_t cfg
);

  pix_fmt_e fmt16;
  logic     force_swap;

  generate
    if (LATER_VARIANT) begin : g_later
      always_comb begin
        force_swap = 1'b0;
        case (depth)
          3'd6:    fmt16 = FMT_565;
          3'd7:    fmt16 = FMT_444;
          default: fmt16 = FMT_5551;
        endcase
      end
    end else begin : g_orig
      always_comb begin
        force_swap = 1'b0;
        case (mux_sel)
          2'd1:    fmt16 = FMT_5551;
          2'd3: begin
            fmt16      = FMT_565;
            force_swap = 1'b1;
          end
          default: fmt16 = FMT_565;
        endcase
      end
    end
  endgenerate

  always_comb begin
    cfg.bswap     = be_byte;
    cfg.msb_first = be_byte | be_pix;
    cfg.swap      = bgr;
    case (depth)
      3'd0, 3'd1, 3'd2, 3'd3: begin
        cfg.fmt  = FMT_INDEX;
        cfg.wlog = depth;
      end
      3'd5: begin
        cfg.fmt  = FMT_888;
        cfg.wlog = 3'd5;
      end
      default: begin
        cfg.fmt  = fmt16;
        cfg.wlog = 3'd4;
        cfg.swap = bgr | force_swap;
      end
    endcase
  end

endmodule

// File: rtl/pix_word_slicer.sv
module pix_word_slicer #(
  parameter int WORD_W = 32,
  localparam int CNT_W = $clog2(WORD_W),
  localparam int NBYTE = WORD_W / 8
) (
  input  logic [WORD_W-1:0] word,
  input  logic              bswap,
  input  logic              msb_first,
  input  logic [2:0]        wlog,
  input  logic [CNT_W-1:0]  cnt,
  output logic [WORD_W-1:0] field
);

  logic [WORD_W-1:0] swapped;
  logic [WORD_W-1:0] src;
  logic [CNT_W:0]    npix;
  logic [CNT_W-1:0]  pos;
  logic [CNT_W-1:0]  offset;
  logic [WORD_W-1:0] mask;

  for (genvar i = 0; i < NBYTE; i++) begin : g_bswap
    assign swapped[8*i +: 8] = word[WORD_W-8-8*i +: 8];
  end

  always_comb begin
    src    = bswap ? swapped : word;
    npix   = (CNT_W+1)'(WORD_W >> wlog);
    pos    = msb_first ? CNT_W'(npix - (CNT_W+1)'(1) - {1'b0, cnt}) : cnt;
    offset = CNT_W'(pos << wlog);
    if (wlog >= 3'd5) mask = WORD_W'(32'h00FF_FFFF);
    else              mask = (WORD_W'(1) << (WORD_W'(1) << wlog)) - WORD_W'(1);
    field  = (src >> offset) & mask;
  end

endmodule

// File: rtl/pix_color_expand.sv
module pix_color_expand
  import pix_unpack_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 8,
  parameter int CH_W   = 8,
  localparam int RGB_W = 3 * CH_W
) (
  input  pix_fmt_e          fmt,
  input  logic              swap,
  input  logic [WORD_W-1:0] field,
  output logic              is_index,
  output logic [IDX_W-1:0]  index,
  output logic [RGB_W-1:0]  rgb
);

  logic [CH_W-1:0] r, g, b;

  always_comb begin
    is_index = 1'b0;
    index    = '0;
    r = '0;
    g = '0;
    b = '0;
    case (fmt)
      FMT_INDEX: begin
        is_index = 1'b1;
        index    = field[IDX_W-1:0];
      end
      FMT_5551: begin
        r = {field[4:0],   3'b000};
        g = {field[9:5],   3'b000};
        b = {field[14:10], 3'b000};
      end
      FMT_565: begin
        r = {field[4:0],   3'b000};
        g = {field[10:5],  2'b00};
        b = {field[15:11], 3'b000};
      end
      FMT_444: begin
        r = {field[3:0],  4'b0000};
        g = {field[7:4],  4'b0000};
        b = {field[11:8], 4'b0000};
      end
      FMT_888: begin
        r = field[7:0];
        g = field[15:8];
        b = field[23:16];
      end
      default: ;
    endcase
    rgb = swap ? {b, g, r} : {r, g, b};
  end

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
  import pix_unpack_pkg::*;
#(
  parameter bit LATER_VARIANT = 1'b0,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 8,
  parameter int CH_W   = 8,
  localparam int CNT_W = $clog2(WORD_W),
  localparam int RGB_W = 3 * CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [WORD_W-1:0] word_data,
  input  logic [2:0]        depth,
  input  logic              bgr,
  input  logic              be_byte,
  input  logic              be_pix,
  input  logic [1:0]        mux_sel,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic              pix_is_index,
  output logic [IDX_W-1:0]  pix_index,
  output logic [RGB_W-1:0]  pix_rgb
);

  unpack_cfg_t       cfg_in, cfg_q;
  logic [WORD_W-1:0] word_q;
  logic              loaded_q, loaded_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, last_idx;
  logic              last, take, accept, cnt_en;
  logic [WORD_W-1:0] field;

  pix_cfg_decode #(.LATER_VARIANT(LATER_VARIANT)) u_decode (
    .depth(depth), .bgr(bgr), .be_byte(be_byte), .be_pix(be_pix),
    .mux_sel(mux_sel), .cfg(cfg_in)
  );

  // Next state
  always_comb begin
    last_idx   = CNT_W'((WORD_W >> cfg_q.wlog) - 1);
    last       = (cnt_q == last_idx);
    take       = loaded_q & pix_ready;
    word_ready = ~loaded_q | (pix_ready & last);
    accept     = word_valid & word_ready;
    cnt_en     = accept | take;
    if (accept)           loaded_d = 1'b1;
    else if (take & last) loaded_d = 1'b0;
    else                  loaded_d = loaded_q;
    if (accept)           cnt_d = '0;
    else                  cnt_d = cnt_q + CNT_W'(1);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      cnt_q    <= '0;
      word_q   <= '0;
      cfg_q    <= '0;
    end else begin
      loaded_q <= loaded_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (accept) begin
        word_q <= word_data;
        cfg_q  <= cfg_in;
      end
    end
  end

  pix_word_slicer #(.WORD_W(WORD_W)) u_slicer (
    .word(word_q), .bswap(cfg_q.bswap), .msb_first(cfg_q.msb_first),
    .wlog(cfg_q.wlog), .cnt(cnt_q), .field(field)
  );

  pix_color_expand #(.WORD_W(WORD_W), .IDX_W(IDX_W), .CH_W(CH_W)) u_expand (
    .fmt(cfg_q.fmt), .swap(cfg_q.swap), .field(field),
    .is_index(pix_is_index), .index(pix_index), .rgb(pix_rgb)
  );

  assign pix_valid = loaded_q;

  // Held pixel under backpressure
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_index)
      && $stable(pix_rgb) && $stable(pix_is_index));

  // No word taken while a pixel waits
  assert_no_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && word_ready && pix_valid |-> pix_ready);

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |-> cnt_q <= last_idx);

  // Back-to-back word leaves no gap
  assert_backtoback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready && word_valid && word_ready |=> pix_valid);

  // Zero fill of widened channels
  assert_widen_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && (cfg_q.fmt == FMT_565 || cfg_q.fmt == FMT_5551)
      |-> pix_rgb[18:16] == 3'b0 && pix_rgb[9:8] == 2'b0 && pix_rgb[2:0] == 3'b0);

endmodule

// File: tb/pix_unpack_bench.sv
module pix_unpack_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n, word_valid, pix_ready, bgr, be_byte, be_pix;
  logic [31:0] word_data;
  logic [2:0]  depth;
  logic [1:0]  mux_sel;
  logic        wr_a, pv_a, ii_a, wr_b, pv_b, ii_b;
  logic [7:0]  ix_a, ix_b;
  logic [23:0] rgb_a, rgb_b;

  int checks = 0;
  int failures = 0;
  logic [31:0] rng = 32'h1234_5678;

  pix_unpack #(.LATER_VARIANT(1'b0)) u_pix_unpack (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(wr_a),
    .word_data(word_data), .depth(depth), .bgr(bgr), .be_byte(be_byte),
    .be_pix(be_pix), .mux_sel(mux_sel), .pix_valid(pv_a), .pix_ready(pix_ready),
    .pix_is_index(ii_a), .pix_index(ix_a), .pix_rgb(rgb_a)
  );

  pix_unpack #(.LATER_VARIANT(1'b1)) u_pix_unpack_later (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(wr_b),
    .word_data(word_data), .depth(depth), .bgr(bgr), .be_byte(be_byte),
    .be_pix(be_pix), .mux_sel(mux_sel), .pix_valid(pv_b), .pix_ready(pix_ready),
    .pix_is_index(ii_b), .pix_index(ix_b), .pix_rgb(rgb_b)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // Expected {is_index, index, rgb} from the requirements
  function automatic logic [32:0] model(input bit later, input int d, input bit sw_in,
      input bit beb, input bit bep, input int mux, input logic [31:0] w, input int k);
    int wc, n, pos, fmt;
    bit sw;
    logic [31:0] src, f;
    logic [7:0] r, g, b;
    sw = sw_in;
    case (d)
      0: wc = 1;
      1: wc = 2;
      2: wc = 4;
      3: wc = 8;
      5: wc = 32;
      default: wc = 16;
    endcase
    if (d <= 3) fmt = 0;
    else if (d == 5) fmt = 4;
    else if (later) fmt = (d == 4) ? 1 : (d == 6) ? 2 : 3;       // R10
    else if (mux == 1) fmt = 1;                                  // R9
    else begin
      fmt = 2;
      if (mux == 3) sw = 1'b1;
    end
    n   = 32 / wc;
    src = beb ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;       // R6
    pos = (beb || bep) ? n - 1 - k : k;                          // R4 R5
    f   = src >> (pos * wc);
    if (wc < 32) f = f & ((32'd1 << wc) - 32'd1);
    else         f = f & 32'h00FF_FFFF;                          // R8
    case (fmt)
      1: begin r = {f[4:0], 3'b0}; g = {f[9:5], 3'b0};  b = {f[14:10], 3'b0}; end
      2: begin r = {f[4:0], 3'b0}; g = {f[10:5], 2'b0}; b = {f[15:11], 3'b0}; end
      3: begin r = {f[3:0], 4'b0}; g = {f[7:4], 4'b0};  b = {f[11:8], 4'b0};  end
      4: begin r = f[7:0];         g = f[15:8];         b = f[23:16];         end
      default: begin r = 8'd0; g = 8'd0; b = 8'd0; end
    endcase
    if (fmt == 0) return {1'b1, f[7:0], 24'd0};                  // R7
    return {1'b0, 8'd0, sw ? {b, g, r} : {r, g, b}};             // R11 R12
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] words [2];
    int prod, cons, k, n, cyc;
    bit pv, exp_wr, take, acc;
    logic [32:0] ea, eb;

    rst_n = 1'b0; word_valid = 1'b0; pix_ready = 1'b0; word_data = '0;
    depth = '0; bgr = 1'b0; be_byte = 1'b0; be_pix = 1'b0; mux_sel = '0;
    repeat (3) @(negedge clk);
    check(!pv_a && wr_a && !pv_b && wr_b, "R1 in reset", {pv_a, wr_a}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    check(!pv_a && wr_a && !pv_b && wr_b, "R1 after release", {pv_a, wr_a}, 2'b01);

    for (int d = 0; d < 8; d++)
      for (int e = 0; e < 4; e++)
        for (int bb = 0; bb < 2; bb++)
          for (int m = 0; m < 4; m++) begin
            depth = 3'(d); be_byte = e[1]; be_pix = e[0]; bgr = bb[0]; mux_sel = 2'(m);
            rng = next_rng(rng); words[0] = rng;
            rng = next_rng(rng); words[1] = rng;
            n = (d <= 3) ? (32 >> d) : (d == 5) ? 1 : 2;
            prod = 0; cons = 0; k = 0; cyc = 0;
            while (cons < 2 && cyc < 400) begin
              rng = next_rng(rng);
              word_valid = (prod < 2) && (rng[2] | rng[3]);
              word_data  = (prod < 2) ? words[prod] : 32'd0;
              pix_ready  = rng[0] | rng[1];
              #1;
              pv = (prod > cons);
              exp_wr = !pv || (pix_ready && k == n - 1);
              check(pv_a == pv && pv_b == pv, "R2 pix_valid", {pv_a, pv_b}, {pv, pv});
              if (pv && pix_ready && k == n - 1)
                check(wr_a && wr_b, "R3 ready on last pixel", {wr_a, wr_b}, 2'b11);
              else
                check(wr_a == exp_wr && wr_b == exp_wr, "R2 word_ready",
                      {wr_a, wr_b}, {exp_wr, exp_wr});
              if (pv) begin
                ea = model(1'b0, d, bb[0], e[1], e[0], m, words[cons], k);
                eb = model(1'b1, d, bb[0], e[1], e[0], m, words[cons], k);
                check({ii_a, ix_a, rgb_a} == ea, "R4-order/R9 pixel original",
                      {ii_a, ix_a, rgb_a}, ea);
                check({ii_b, ix_b, rgb_b} == eb, "R10 pixel later",
                      {ii_b, ix_b, rgb_b}, eb);
              end
              take = pv && pix_ready;
              acc  = word_valid && exp_wr;
              if (take) begin
                if (k == n - 1) begin k = 0; cons++; end
                else k++;
              end
              if (acc) prod++;
              cyc++;
              @(negedge clk);
            end
            word_valid = 1'b0;
            pix_ready  = 1'b0;
            #1;
            check(!pv_a && !pv_b && cons == 2, "R2 drained", {pv_a, pv_b}, 2'b00);
            @(negedge clk);
          end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule